// File: doc/BRIEF.md
# Serial programming mode entry detector

This block sits on the device side of a two-wire serial programming port, next to the external reset pin. It samples the reset pin, the serial clock and the serial data line in the system clock domain and decides when the device may enter its serial program/verify mode. An entry attempt has four steps. The reset pin pulses high and returns low. While the pin stays low, a 32-bit entry key arrives on the serial lines. The pin is then raised within a bounded window. A guard delay follows, after which the mode becomes active. All intervals are counted in system clock cycles.

Once the reset pin is raised after a matching key, the block requests that unused I/Os go to high impedance. When the guard delay has elapsed it asserts the mode-active output. From then on it forwards each serial data bit, captured on a serial clock rising edge, to the command logic that follows. Bits clocked before the guard delay expires are dropped. Lowering the reset pin leaves the mode at once.

Top module: `prog_entry_detect`

## Requirements
- R1: After rst_ni is released, prog_mode_o, io_hiz_o and bit_vld_o are all 0.
- R2: A key equal to 0x4D434851 enters the mode. The key is sampled on ser_clk_i rising edges, most significant bit first, while rst_pin_i is low, right after a high-then-low pulse on rst_pin_i, and rst_pin_i must then be raised.
- R3: A key that differs from 0x4D434851 in any single bit position leaves prog_mode_o at 0.
- R4: After a mismatching key, a further key sent without a new high-then-low pulse on rst_pin_i is ignored, and raising the pin afterwards does not enter the mode.
- R5: Raising rst_pin_i well inside WIN_CYC cycles after the last key bit enters the mode. Raising it only after the window has expired does not.
- R6: After a valid key, io_hiz_o goes to 1 within a few cycles of rst_pin_i rising. prog_mode_o stays 0 until about GUARD_CYC cycles have passed and is 1 afterwards.
- R7: Serial clock edges that arrive during the guard delay produce no bit_vld_o pulse. Once the mode is active, each ser_clk_i rising edge produces exactly one bit_vld_o pulse, with bit_o equal to ser_dat_i at that edge.
- R8: When rst_pin_i falls while the mode is active, prog_mode_o and io_hiz_o return to 0 within a few cycles.
- R9: A rise of rst_pin_i part-way through a key discards the partial key and counts as the start of a new pulse. A full valid key that follows is accepted.
- R10: Raising rst_pin_i after only 31 key bits does not enter the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rst_pin_i | input | 1 | External reset pin level (asynchronous) |
| ser_clk_i | input | 1 | Serial programming clock (asynchronous) |
| ser_dat_i | input | 1 | Serial programming data (asynchronous) |
| io_hiz_o | output | 1 | Request to place unused I/Os in high impedance |
| prog_mode_o | output | 1 | Program/verify mode active |
| bit_vld_o | output | 1 | One-cycle strobe: a serial bit was received in mode |
| bit_o | output | 1 | Serial bit value, valid with bit_vld_o |

## Verification
The main function is tried with the exact key, then with each of the 32 single-bit corruptions of it. This shows that every bit position is compared and that the bit order is most significant first. Keys that are too short, keys that lack a preceding pulse, and keys cut short by a pin rise separate the pulse-low-high sequencing from the plain comparison. A sweep of the delay before the pin is raised places the window. Probes before and after the guard delay, with a clock edge sent during it, tell the high-impedance request apart from the mode-active output and from bit forwarding.

// File: rtl/prog_entry_pkg.sv
package prog_entry_pkg;
  localparam int unsigned KEY_W = 32;
  localparam logic [KEY_W-1:0] ENTRY_KEY = 32'h4D43_4851;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_KEY,
    ST_ARM,
    ST_GUARD,
    ST_ACTIVE
  } entry_st_e;
endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/key_shift.sv
module key_shift #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] KEY = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic shift_i,
  input  logic bit_i,
  output logic full_o,
  output logic match_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [W-1:0]     word_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == CNT_W'(W));
  assign match_o = full_o && (word_q == KEY);

  // first bit received ends up in the MSb
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (shift_i && !full_o) begin
      word_q <= {word_q[W-2:0], bit_i};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(W));

  a_r2_shift_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !clear_i && !full_o) |=> (word_q[0] == $past(bit_i)));
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          en_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (en_i && !done_o) cnt_q <= cnt_q - 1'b1;
  end

  a_r5_timer_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/prog_entry_detect.sv
module prog_entry_detect
  import prog_entry_pkg::*;
#(
  parameter int unsigned WIN_CYC     = 40,
  parameter int unsigned GUARD_CYC   = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_pin_i,
  input  logic ser_clk_i,
  input  logic ser_dat_i,
  output logic io_hiz_o,
  output logic prog_mode_o,
  output logic bit_vld_o,
  output logic bit_o
);
  localparam int unsigned T_MAX = (WIN_CYC > GUARD_CYC) ? WIN_CYC : GUARD_CYC;
  localparam int unsigned CW    = $clog2(T_MAX + 1);

  logic [2:0] raw, syn;
  logic       pin_hi, sck, sdat, sck_prev_q, sck_rise;

  assign raw = {rst_pin_i, ser_clk_i, ser_dat_i};

  sync_bits #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign pin_hi = syn[2];
  assign sck    = syn[1];
  assign sdat   = syn[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_prev_q <= 1'b0;
    else         sck_prev_q <= sck;
  end
  assign sck_rise = sck && !sck_prev_q;

  entry_st_e     st_q, st_d;
  logic          key_clr, key_shift_en, key_full, key_match;
  logic          t_load, t_en, t_done;
  logic [CW-1:0] t_val;

  key_shift #(.W(KEY_W), .KEY(ENTRY_KEY)) i_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(key_clr),
    .shift_i(key_shift_en),
    .bit_i  (sdat),
    .full_o (key_full),
    .match_o(key_match)
  );

  hold_timer #(.CW(CW)) i_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (t_load),
    .load_val_i(t_val),
    .en_i      (t_en),
    .done_o    (t_done)
  );

  always_comb begin
    st_d         = st_q;
    key_clr      = 1'b0;
    key_shift_en = 1'b0;
    t_load       = 1'b0;
    t_val        = '0;
    t_en         = 1'b0;
    unique case (st_q)
      ST_IDLE: if (pin_hi) st_d = ST_PULSE;
      ST_PULSE: begin
        key_clr = 1'b1;
        if (!pin_hi) st_d = ST_KEY;
      end
      ST_KEY: begin
        if (pin_hi) st_d = ST_PULSE;  // early rise restarts the attempt
        else if (key_full) begin
          if (key_match) begin
            st_d   = ST_ARM;
            t_load = 1'b1;
            t_val  = CW'(WIN_CYC);
          end else begin
            st_d = ST_IDLE;
          end
        end else key_shift_en = sck_rise;
      end
      ST_ARM: begin
        t_en = 1'b1;
        if (pin_hi) begin
          st_d   = ST_GUARD;
          t_load = 1'b1;
          t_val  = CW'(GUARD_CYC);
        end else if (t_done) st_d = ST_IDLE;
      end
      ST_GUARD: begin
        t_en = 1'b1;
        if (!pin_hi)     st_d = ST_IDLE;
        else if (t_done) st_d = ST_ACTIVE;
      end
      ST_ACTIVE: if (!pin_hi) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_vld_o <= 1'b0;
      bit_o     <= 1'b0;
    end else begin
      st_q      <= st_d;
      bit_vld_o <= (st_q == ST_ACTIVE) && sck_rise;
      bit_o     <= sdat;
    end
  end

  assign prog_mode_o = (st_q == ST_ACTIVE);
  assign io_hiz_o    = (st_q == ST_GUARD) || (st_q == ST_ACTIVE);

  a_r6_hiz_before_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_mode_o) |-> $past(io_hiz_o));

  a_r8_drop_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_mode_o && !pin_hi) |=> (!prog_mode_o && !io_hiz_o));

  a_r7_vld_in_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |-> $past(prog_mode_o));
endmodule

// File: tb/test_prog_entry_detect.sv
module test_prog_entry_detect;
  localparam int unsigned WIN   = 40;
  localparam int unsigned GUARD = 20;
  localparam logic [31:0] KEY   = 32'h4D43_4851;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_pin = 1'b0, sclk = 1'b0, sdat = 1'b0;
  logic io_hiz, prog_mode, bit_vld, bit_v;

  int n_chk = 0, n_fail = 0, vld_cnt = 0;
  logic [15:0] cap = '0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  prog_entry_detect #(.WIN_CYC(WIN), .GUARD_CYC(GUARD), .SYNC_STAGES(2)) i_prog_entry_detect (
    .clk_i(clk), .rst_ni(rst_n), .rst_pin_i(rst_pin), .ser_clk_i(sclk),
    .ser_dat_i(sdat), .io_hiz_o(io_hiz), .prog_mode_o(prog_mode),
    .bit_vld_o(bit_vld), .bit_o(bit_v)
  );

  always @(negedge clk) if (bit_vld) begin
    vld_cnt <= vld_cnt + 1;
    cap     <= {cap[14:0], bit_v};
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdat = b; wc(2);
    sclk = 1'b1; wc(4);
    sclk = 1'b0; wc(2);
  endtask

  task automatic send_key(input logic [31:0] k, input int nbits);
    for (int j = 0; j < nbits; j++) send_bit(k[31-j]);
  endtask

  task automatic pulse();
    rst_pin = 1'b1; wc(6);
    rst_pin = 1'b0; wc(6);
  endtask

  // full attempt; returns prog_mode after guard, then drops the pin
  task automatic attempt(input logic [31:0] k, input int nbits, input int d, output logic ok);
    pulse();
    send_key(k, nbits);
    wc(d);
    rst_pin = 1'b1;
    wc(GUARD + 12);
    ok = prog_mode;
    rst_pin = 1'b0;
    wc(8);
  endtask

  initial begin
    logic ok;
    wc(3);
    rst_n = 1'b1;
    wc(3);
    chk("R1 prog_mode", prog_mode, 0);
    chk("R1 io_hiz", io_hiz, 0);
    chk("R1 bit_vld", bit_vld, 0);

    // R2, R6, R7, R8: full entry with probes
    pulse();
    send_key(KEY, 32);
    wc(4);
    rst_pin = 1'b1;
    wc(6);
    chk("R6 hiz after raise", io_hiz, 1);
    chk("R6 mode held in guard", prog_mode, 0);
    sclk = 1'b1; wc(2); sclk = 1'b0;   // edge during guard, must be dropped
    wc(GUARD - 10);
    chk("R6 mode before guard end", prog_mode, 0);
    wc(12);
    chk("R2 R6 mode active", prog_mode, 1);
    chk("R7 no bit during guard", vld_cnt, 0);
    send_key(32'hA500_0000, 8);
    wc(2);
    chk("R7 bit count", vld_cnt, 8);
    chk("R7 bit values", cap[7:0], 8'hA5);
    rst_pin = 1'b0;
    wc(6);
    chk("R8 mode off", prog_mode, 0);
    chk("R8 hiz off", io_hiz, 0);
    wc(4);

    // R3: every single-bit corruption
    for (int i = 0; i < 32; i++) begin
      attempt(KEY ^ (32'h1 << i), 32, 4, ok);
      chk($sformatf("R3 flip bit %0d", i), ok, 0);
    end
    attempt(KEY, 32, 4, ok);
    chk("R2 key after flips", ok, 1);

    // R4: mismatch, then good key with no new pulse
    pulse();
    send_key(~KEY, 32);
    wc(10);
    send_key(KEY, 32);
    wc(4);
    rst_pin = 1'b1;
    wc(GUARD + 12);
    chk("R4 no pulse no entry", prog_mode, 0);
    rst_pin = 1'b0;
    wc(8);

    // R5: raise delay sweep
    attempt(KEY, 32, 1, ok);           chk("R5 delay 1", ok, 1);
    attempt(KEY, 32, 8, ok);           chk("R5 delay 8", ok, 1);
    attempt(KEY, 32, WIN - 12, ok);    chk("R5 delay inside", ok, 1);
    attempt(KEY, 32, WIN + 8, ok);     chk("R5 delay past window", ok, 0);
    attempt(KEY, 32, WIN + 20, ok);    chk("R5 delay far past", ok, 0);

    // R9: partial key aborted by a pin rise, then full key
    pulse();
    send_key(KEY, 10);
    attempt(KEY, 32, 4, ok);
    chk("R9 restart after partial", ok, 1);

    // R10: too few bits
    attempt(KEY, 31, 4, ok);
    chk("R10 31 bits", ok, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule